// File: doc/BRIEF.md
# Prioritized Exception Cause Selector

This block turns a raw set of raised exception flags into a single trap cause. A 16-bit vector carries one flag per cause number. A 3-bit source code names the unit that produced the vector. The block first clears every flag that the named source is not allowed to raise. It then picks one surviving flag by a fixed priority order. That order is not numeric: breakpoint is the highest and load access fault is the lowest.

The block is purely combinational. It returns the filtered vector, a valid flag and the 4-bit number of the winning cause. The commit or trap logic downstream uses the winner directly and needs no priority logic of its own.

Cause numbers are: 0 instruction misaligned, 1 instruction access fault, 2 illegal instruction, 3 breakpoint, 4 load misaligned, 5 load access fault, 6 store misaligned, 7 store access fault, 8 environment call from user, 9 environment call from supervisor, 11 environment call from machine, 12 instruction page fault, 13 load page fault, 15 store page fault. Positions 10 and 14 are undefined.

Top module: `exc_cause_sel`

## Requirements
- R1: Source code 1 (instruction fetch) keeps only bits 0, 1, 2 and 12 of the input in `masked_vec`.
- R2: Source code 2 (load) keeps only bits 4, 5 and 13. Source code 3 (store address) keeps only bits 6, 7 and 15.
- R3: Source code 4 (atomic) keeps the union of the load and store-address sets: bits 4, 5, 6, 7, 13 and 15.
- R4: Source code 5 (system register access) keeps bits 2, 3, 8, 9 and 11. Source code 6 (fence) keeps only bit 2.
- R5: Source code 0 keeps every defined cause. Bits 10 and 14 of `masked_vec` are always 0. Source code 7 keeps nothing.
- R6: A bit of `masked_vec` is never 1 where the same input bit is 0.
- R7: When several bits survive masking, the winner is the first survivor in this order, highest first: 3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5.
- R8: `exc_valid` is 1 exactly when at least one bit of `masked_vec` is 1.
- R9: When `exc_valid` is 0, `exc_cause` is 0.
- R10: `exc_cause` is the plain binary bit position of the winning flag. For example, a lone surviving bit 11 gives 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| exc_vec | input | 16 | Raised exception flags, one per cause number |
| src_sel | input | 3 | Code of the unit that raised the vector |
| masked_vec | output | 16 | Flags left after the per-source filter |
| exc_valid | output | 1 | At least one flag survived |
| exc_cause | output | 4 | Number of the winning cause, 0 when none |

## Verification
Each of the eight source codes is first tried with every single-bit vector. Single-bit vectors separate the per-source filter from the priority logic: each one shows whether that exact position passes, and whether its number comes out unchanged. The all-ones and all-zeros vectors then show the full filter and the empty case. Random multi-bit vectors for every source show whether the ordering picks the correct winner among competing survivors. These results are checked against an order list that the bench holds separately.

// File: rtl/exc_sel_pkg.sv
// Package: shared widths, source codes and the fixed cause ranking.
// Assumes a 16-entry cause space with 4-bit cause numbers.
package exc_sel_pkg;
    localparam int NUM_CAUSE  = 16;
    localparam int CAUSE_W    = $clog2(NUM_CAUSE);
    localparam int NUM_RANKED = 14;
    localparam int SRC_W      = 3;

    // Bits that name a real cause (10 and 14 are holes)
    localparam logic [NUM_CAUSE-1:0] DEFINED_CAUSES = 16'hBBFF;

    typedef enum logic [SRC_W-1:0] {
        SRC_ANY    = 3'd0,
        SRC_FETCH  = 3'd1,
        SRC_LOAD   = 3'd2,
        SRC_STADDR = 3'd3,
        SRC_ATOMIC = 3'd4,
        SRC_SYSREG = 3'd5,
        SRC_FENCE  = 3'd6,
        SRC_NONE   = 3'd7
    } exc_src_e;

    // Cause number held at a given rank; rank 0 is the highest priority
    function automatic int rank_cause(input int rank);
        case (rank)
            0:  return 3;
            1:  return 12;
            2:  return 1;
            3:  return 2;
            4:  return 0;
            5:  return 11;
            6:  return 9;
            7:  return 8;
            8:  return 6;
            9:  return 4;
            10: return 15;
            11: return 13;
            12: return 7;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/exc_src_keep.sv
// Module: decodes the source code into a keep mask of allowed causes.
// Assumes the source encoding of exc_sel_pkg; unknown codes keep nothing.
module exc_src_keep
    import exc_sel_pkg::*;
(
    input  logic [SRC_W-1:0]     src_sel,
    output logic [NUM_CAUSE-1:0] keep
);
    logic [NUM_CAUSE-1:0] raw_keep;

    // Per-source table of the causes that source may legally raise
    always_comb begin
        case (exc_src_e'(src_sel))
            SRC_ANY:    raw_keep = DEFINED_CAUSES;
            SRC_FETCH:  raw_keep = 16'h1007;
            SRC_LOAD:   raw_keep = 16'h2030;
            SRC_STADDR: raw_keep = 16'h80C0;
            SRC_ATOMIC: raw_keep = 16'hA0F0;
            SRC_SYSREG: raw_keep = 16'h0B0C;
            SRC_FENCE:  raw_keep = 16'h0004;
            default:    raw_keep = '0;
        endcase
    end

    // Clip the table to defined positions so holes can never pass
    assign keep = raw_keep & DEFINED_CAUSES;

    // R5
    always_comb begin
        keep_no_hole_chk: assert ((keep[10] == 1'b0) && (keep[14] == 1'b0))
            else $error("keep mask opens an undefined cause");
    end
endmodule

// File: rtl/exc_vec_filter.sv
// Module: bitwise filter of the raised flags by the keep mask.
// Assumes both vectors share the cause numbering.
module exc_vec_filter #(
    parameter int N = 16
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] keep,
    output logic [N-1:0] kept
);
    // One gate per cause position
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign kept[i] = flags[i] & keep[i];
    end

    // R6
    always_comb begin
        kept_subset_chk: assert ((kept & ~flags) == '0)
            else $error("filtered flag set without input flag");
    end
endmodule

// File: rtl/exc_rank_pick.sv
// Module: selects the highest-ranked set flag using the package ranking.
// Assumes unranked positions are already cleared by the filter.
module exc_rank_pick
    import exc_sel_pkg::*;
(
    input  logic [NUM_CAUSE-1:0] flags,
    output logic                 hit,
    output logic [CAUSE_W-1:0]   cause
);
    // Walk from lowest rank up so the highest-ranked survivor is written last
    always_comb begin
        hit   = 1'b0;
        cause = '0;
        for (int r = NUM_RANKED - 1; r >= 0; r--) begin
            if (flags[rank_cause(r)]) begin
                hit   = 1'b1;
                cause = CAUSE_W'(rank_cause(r));
            end
        end
    end

    // R8
    always_comb begin
        hit_points_at_flag_chk: assert (!hit || flags[cause])
            else $error("winner is not a set flag");
    end

    // R9
    always_comb begin
        idle_cause_zero_chk: assert (hit || (cause == '0 && flags == '0))
            else $error("no winner but cause or flags nonzero");
    end

    // R7
    always_comb begin
        for (int r = 0; r < NUM_RANKED; r++) begin
            if (rank_cause(r) == int'(cause)) break;
            no_higher_rank_chk: assert (!hit || !flags[rank_cause(r)])
                else $error("a higher ranked flag was passed over");
        end
    end
endmodule

// File: rtl/exc_cause_sel.sv
// Module: top of the cause selector; filters the flags by source, then ranks them.
// Assumes purely combinational use inside the commit stage.
module exc_cause_sel
    import exc_sel_pkg::*;
(
    input  logic [15:0] exc_vec,
    input  logic [2:0]  src_sel,
    output logic [15:0] masked_vec,
    output logic        exc_valid,
    output logic [3:0]  exc_cause
);
    logic [NUM_CAUSE-1:0] keep_mask;

    exc_src_keep u_keep (
        .src_sel (src_sel),
        .keep    (keep_mask)
    );

    exc_vec_filter #(.N(NUM_CAUSE)) u_filter (
        .flags (exc_vec),
        .keep  (keep_mask),
        .kept  (masked_vec)
    );

    exc_rank_pick u_pick (
        .flags (masked_vec),
        .hit   (exc_valid),
        .cause (exc_cause)
    );
endmodule

// File: tb/exc_cause_sel_tb.sv
module exc_cause_sel_tb;
    logic        clk = 1'b0;
    logic [15:0] exc_vec;
    logic [2:0]  src_sel;
    logic [15:0] masked_vec;
    logic        exc_valid;
    logic [3:0]  exc_cause;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    exc_cause_sel u_dut (
        .exc_vec(exc_vec), .src_sel(src_sel),
        .masked_vec(masked_vec), .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    int order [14] = '{3, 12, 1, 2, 0, 11, 9, 8, 6, 4, 15, 13, 7, 5};

    function automatic logic [15:0] bits_of(input int a, b, c, d, e, f);
        logic [15:0] m = '0;
        if (a >= 0) m[a] = 1'b1;
        if (b >= 0) m[b] = 1'b1;
        if (c >= 0) m[c] = 1'b1;
        if (d >= 0) m[d] = 1'b1;
        if (e >= 0) m[e] = 1'b1;
        if (f >= 0) m[f] = 1'b1;
        return m;
    endfunction

    function automatic logic [15:0] exp_keep(input int s);
        case (s)
            0: return ~bits_of(10, 14, -1, -1, -1, -1);
            1: return bits_of(0, 1, 2, 12, -1, -1);
            2: return bits_of(4, 5, 13, -1, -1, -1);
            3: return bits_of(6, 7, 15, -1, -1, -1);
            4: return bits_of(4, 5, 13, 6, 7, 15);
            5: return bits_of(2, 3, 8, 9, 11, -1);
            6: return bits_of(2, -1, -1, -1, -1, -1);
            default: return '0;
        endcase
    endfunction

    function automatic string mask_req(input int s);
        case (s)
            1: return "R1";
            2, 3: return "R2";
            4: return "R3";
            5, 6: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic apply_and_check(input logic [15:0] v, input int s);
        logic [15:0] em;
        logic ev;
        logic [3:0] ec;
        @(negedge clk);
        exc_vec = v;
        src_sel = 3'(s);
        #1;
        em = v & exp_keep(s);
        ev = 1'b0;
        ec = 4'd0;
        for (int k = 0; k < 14; k++) begin
            if (!ev && em[order[k]]) begin ev = 1'b1; ec = 4'(order[k]); end
        end
        checks++;
        if (masked_vec !== em) begin
            errors++;
            $display("FAIL %s src=%0d vec=%h masked actual=%h expected=%h", mask_req(s), s, v, masked_vec, em);
        end
        checks++;
        if (exc_valid !== ev) begin
            errors++;
            $display("FAIL R8 src=%0d vec=%h valid actual=%b expected=%b", s, v, exc_valid, ev);
        end
        checks++;
        if (exc_cause !== ec) begin
            errors++;
            $display("FAIL %s src=%0d vec=%h cause actual=%0d expected=%0d",
                     ev ? "R7" : "R9", s, v, exc_cause, ec);
        end
    endtask

    initial begin
        exc_vec = '0;
        src_sel = '0;
        // Idle state: no flags, nothing valid (R8, R9)
        apply_and_check(16'h0000, 0);
        // R6: every position kept but no input flag set
        apply_and_check(16'h0000, 0);
        checks++;
        if (masked_vec !== 16'h0) begin
            errors++;
            $display("FAIL R6 masked actual=%h expected=0000", masked_vec);
        end
        // Single-bit sweep for every source; R10 checked in the open mode
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < 16; b++) begin
                apply_and_check(16'(1) << b, s);
                if (s == 0 && b != 10 && b != 14) begin
                    checks++;
                    if (exc_cause !== 4'(b)) begin
                        errors++;
                        $display("FAIL R10 bit=%0d cause actual=%0d expected=%0d", b, exc_cause, b);
                    end
                end
            end
        end
        // All flags raised: shows each full filter; R5 holes stay zero
        for (int s = 0; s < 8; s++) apply_and_check(16'hFFFF, s);
        checks++;
        if (masked_vec[10] !== 1'b0 || masked_vec[14] !== 1'b0) begin
            errors++;
            $display("FAIL R5 holes actual=%b%b expected=00", masked_vec[14], masked_vec[10]);
        end
        // R7: competing survivors, random mixes
        for (int s = 0; s < 8; s++) begin
            for (int n = 0; n < 300; n++) apply_and_check(16'($urandom), s);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule